// File: doc/BRIEF.md
# Boot Source Tag Responder

This block lives inside a peripheral on the processor I/O channel and answers the boot-load handshake when that peripheral is the chosen boot source. The processor raises a boot request line and drives a two-bit source code, and it pulses system reset around them. The block watches these lines and a strap that places the device as either the primary or the alternate boot source. It clears its boot tag whenever the request and reset are active together. After the reset ends it raises the tag, but only if the captured source code names this device. It also gives a stretched internal reset to the rest of the peripheral.

All channel inputs pass through synchronizer stages before use. The block arms on the level of request AND reset, so it works whichever of the two arrives first. The leading edge of reset is never used as a trigger. The source code is sampled only while the block is arming and is not read again. After reset release the tag rises after a fixed number of logic cycles, and it falls when the processor drops the request.

Top module: `boot_tag_responder`

## Requirements
- R1: When the synchronized request and reset are both high, `boot_tag_o` is low SYNC_STAGES+1 clock cycles after both inputs are driven high.
- R2: `boot_tag_o` stays low for as long as the synchronized system reset is high.
- R3: `dev_reset_o` rises SYNC_STAGES+1 cycles after `sys_reset_i` rises. It falls SYNC_STAGES+1+RST_HOLD cycles after `sys_reset_i` falls. This holds whether or not a boot request is present.
- R4: A selected device raises `boot_tag_o` exactly SYNC_STAGES+1+TAG_DELAY cycles after `sys_reset_i` falls. TAG_DELAY is at least 1, so the delay is never zero.
- R5: Source code encoding: bit 0 of `boot_status_i` names the primary source and bit 1 names the alternate source. With `strap_alt_i`=0 the device is selected when bit 0 is set. With `strap_alt_i`=1 it is selected when bit 1 is set.
- R6: A device that is not selected keeps `boot_tag_o` low for the whole sequence.
- R7: Arming depends only on request and reset being high together, with either one arriving first. A system reset with no request never raises the tag.
- R8: The source code is captured while request and reset are both high. Changes to `boot_status_i` after reset release do not change the outcome.
- R9: When `init_boot_i` falls, `boot_tag_o` goes low SYNC_STAGES+1 cycles later and the block returns to idle, so a later sequence works again.
- R10: While `rst_ni` is low, `boot_tag_o` and `dev_reset_o` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_boot_i | input | 1 | Boot request from the channel, asynchronous |
| boot_status_i | input | 2 | Boot source code: bit 0 primary, bit 1 alternate |
| sys_reset_i | input | 1 | Channel system reset, asynchronous |
| strap_alt_i | input | 1 | 0 places the device as primary, 1 as alternate |
| boot_tag_o | output | 1 | Boot tag returned to the channel |
| dev_reset_o | output | 1 | Stretched internal reset for the device |

## Verification
Two outputs can change in the same cycle: the tag is cleared when the block re-arms, and the internal reset rises from the same system reset. The bench brings a selected device to the tagged state. It then raises system reset while the request is still held. It counts cycles to the first edge where the tag is low and the internal reset is high, and both must land exactly SYNC_STAGES+1 cycles after the stimulus. The bench then releases reset and checks that the tag comes back after the full release delay. Elsewhere, each strap and code combination is swept with both arrival orders, and the code is flipped after release to show it is not read again.

// File: rtl/boot_tag_pkg.sv
package boot_tag_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_WAIT  = 3'd2,
    ST_TAG   = 3'd3,
    ST_DONE  = 3'd4
  } boot_state_e;

  // bit 0 names the primary source, bit 1 the alternate
  function automatic logic src_match(input logic [1:0] code, input logic alt);
    return alt ? code[1] : code[0];
  endfunction
endpackage

// File: rtl/boot_sync.sv
module boot_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/boot_rst_stretch.sv
module boot_rst_stretch #(
  parameter int unsigned HOLD = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic rst_o
);
  localparam int unsigned HW = (HOLD > 0) ? $clog2(HOLD + 1) : 1;
  localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

  logic [HW-1:0] cnt_q;
  logic          rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      if (req_i)             cnt_q <= HOLD_V;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      rst_q <= req_i | (cnt_q != '0);
    end
  end

  assign rst_o = rst_q;
endmodule

// File: rtl/boot_seq_fsm.sv
module boot_seq_fsm
  import boot_tag_pkg::*;
#(
  parameter int unsigned TAG_DELAY = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_i,
  input  logic       sreset_i,
  input  logic [1:0] status_i,
  input  logic       strap_alt_i,
  output logic       tag_o
);
  localparam int unsigned CW = (TAG_DELAY > 1) ? $clog2(TAG_DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(TAG_DELAY - 1);

  boot_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sel_q, sel_d;
  logic          arm;

  assign arm = init_i & sreset_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sel_d   = sel_q;
    if (arm) begin
      state_d = ST_ARMED;
      cnt_d   = '0;
      // code is only valid while the request is up
      sel_d   = src_match(status_i, strap_alt_i);
    end else if (sreset_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = ST_IDLE;
        ST_ARMED: begin
          if (!init_i)    state_d = ST_IDLE;
          else if (sel_q) state_d = ST_WAIT;
          else            state_d = ST_DONE;
          cnt_d = '0;
        end
        ST_WAIT: begin
          if (!init_i)            state_d = ST_IDLE;
          else if (cnt_q == LAST) state_d = ST_TAG;
          else                    cnt_d   = cnt_q + 1'b1;
        end
        ST_TAG:  if (!init_i) state_d = ST_DONE;
        ST_DONE: if (!init_i) state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sel_q   <= sel_d;
    end
  end

  assign tag_o = (state_q == ST_TAG);
endmodule

// File: rtl/boot_tag_responder.sv
module boot_tag_responder #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TAG_DELAY   = 3,
  parameter int unsigned RST_HOLD    = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       init_boot_i,
  input  logic [1:0] boot_status_i,
  input  logic       sys_reset_i,
  input  logic       strap_alt_i,
  output logic       boot_tag_o,
  output logic       dev_reset_o
);
  localparam int unsigned SW = 5;

  logic [SW-1:0] raw, syn;
  logic          init_s, sreset_s, strap_s;
  logic [1:0]    status_s;

  assign raw = {strap_alt_i, boot_status_i, sys_reset_i, init_boot_i};

  boot_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign init_s   = syn[0];
  assign sreset_s = syn[1];
  assign status_s = syn[3:2];
  assign strap_s  = syn[4];

  boot_seq_fsm #(.TAG_DELAY(TAG_DELAY)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_s),
    .sreset_i   (sreset_s),
    .status_i   (status_s),
    .strap_alt_i(strap_s),
    .tag_o      (boot_tag_o)
  );

  boot_rst_stretch #(.HOLD(RST_HOLD)) u_stretch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (sreset_s),
    .rst_o (dev_reset_o)
  );
endmodule

// File: rtl/boot_tag_responder_chk.sv
module boot_tag_responder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic init_s_i,
  input logic rst_s_i,
  input logic tag_i,
  input logic dev_i
);
  p_and_clears_tag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_s_i && rst_s_i) |=> !tag_i);

  p_no_tag_in_reset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_s_i |=> !tag_i);

  p_reset_reaches_dev_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_s_i |=> dev_i);

  p_tag_after_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tag_i) |-> ($past(!rst_s_i) && $past(init_s_i)));

  p_tag_needs_request_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_s_i |=> !tag_i);

  always_comb begin
    if (!rst_ni) begin
      a_idle_outputs_r10: assert (!tag_i && !dev_i);
    end
  end
endmodule

bind boot_tag_responder boot_tag_responder_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .init_s_i(init_s),
  .rst_s_i (sreset_s),
  .tag_i   (boot_tag_o),
  .dev_i   (dev_reset_o)
);

// File: tb/boot_tag_responder_bench.sv
module boot_tag_responder_bench;
  localparam int SYNC = 2;
  localparam int DLY  = 3;
  localparam int HOLD = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       init_boot = 1'b0;
  logic [1:0] status = 2'b00;
  logic       sreset = 1'b0;
  logic       strap = 1'b0;
  logic       tag, dev;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  boot_tag_responder #(.SYNC_STAGES(SYNC), .TAG_DELAY(DLY), .RST_HOLD(HOLD)) u_boot_tag_responder (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .init_boot_i  (init_boot),
    .boot_status_i(status),
    .sys_reset_i  (sreset),
    .strap_alt_i  (strap),
    .boot_tag_o   (tag),
    .dev_reset_o  (dev)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // kind 0: tag, 1: dev
  task automatic measure(input int kind, input logic val, input int maxc, output int n);
    n = -1;
    for (int k = 1; k <= maxc; k++) begin
      @(negedge clk);
      if (((kind == 0) ? tag : dev) == val) begin
        n = k;
        break;
      end
    end
  endtask

  task automatic run_seq(input logic alt, input logic [1:0] code, input int order);
    int  n;
    int  bad;
    logic sel;
    sel = alt ? code[1] : code[0];
    strap = alt; status = 2'b00; init_boot = 0; sreset = 0;
    repeat (8) @(negedge clk);
    if (order == 0) begin
      init_boot = 1; status = code;
      repeat (2) @(negedge clk);
      sreset = 1;
      measure(1, 1'b1, 10, n);
      check("R3 dev rise", n, SYNC + 1);
      repeat (4) @(negedge clk);
    end else begin
      sreset = 1;  // R7: reset leads request
      repeat (3) @(negedge clk);
      init_boot = 1; status = code;
      repeat (4) @(negedge clk);
    end
    bad = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (tag) bad++;
    end
    check("R2 tag in reset", bad, 0);
    sreset = 0;
    status = ~code;  // R8: not read again
    measure(0, 1'b1, SYNC + 1 + DLY + 4, n);
    check(sel ? "R4 R5 R7 R8 tag rise" : "R6 R5 R8 unselected", n, sel ? SYNC + 1 + DLY : -1);
    init_boot = 0;
    if (sel) begin
      measure(0, 1'b0, 10, n);
      check("R9 tag drop", n, SYNC + 1);
    end
    repeat (SYNC + 3) @(negedge clk);
    check("R9 idle tag", int'(tag), 0);
  endtask

  initial begin
    int n;
    int k_tag, k_dev;
    repeat (3) @(negedge clk);
    check("R10 reset tag", int'(tag), 0);
    check("R10 reset dev", int'(dev), 0);
    rst_n = 1;

    for (int alt = 0; alt < 2; alt++)
      for (int code = 0; code < 4; code++)
        for (int order = 0; order < 2; order++)
          run_seq(alt[0], code[1:0], order);

    // reset with no request, code tempting
    strap = 0; status = 2'b01; init_boot = 0;
    repeat (4) @(negedge clk);
    sreset = 1;
    repeat (6) @(negedge clk);
    sreset = 0;
    measure(1, 1'b0, 12, n);
    check("R3 dev fall", n, SYNC + 1 + HOLD);
    measure(0, 1'b1, 12, n);
    check("R7 no request no tag", n, -1);

    // re-arm while tagged: tag clear and dev rise together
    strap = 1; status = 2'b10; init_boot = 1;
    repeat (2) @(negedge clk);
    sreset = 1;
    repeat (6) @(negedge clk);
    sreset = 0;
    measure(0, 1'b1, 12, n);
    check("R4 first tag", n, SYNC + 1 + DLY);
    repeat (3) @(negedge clk);
    sreset = 1;
    k_tag = -1; k_dev = -1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k_tag < 0 && !tag) k_tag = k;
      if (k_dev < 0 && dev) k_dev = k;
    end
    check("R1 tag clear on re-arm", k_tag, SYNC + 1);
    check("R3 dev rise on re-arm", k_dev, SYNC + 1);
    sreset = 0;
    measure(0, 1'b1, 12, n);
    check("R4 tag after re-arm", n, SYNC + 1 + DLY);
    init_boot = 0;
    measure(0, 1'b0, 10, n);
    check("R9 final drop", n, SYNC + 1);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule